// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Pad-Mode Decoding

This block controls one port of eight general-purpose I/O pins. Software sets each pin through two read/write registers on a simple peripheral register bus. The direction register picks input or output. The output register sets the level a pin drives. When a pin is an input, the same output bit instead enables that pin's weak pull-up. Together the two bits select one of four pad states: floating input, input with weak pull-up, strong low, or strong high. The block turns them into three pad control vectors: output enable, drive value and pull-up enable.

A third register holds one alternate-function enable bit per pin. When a pin's bit is set, an alternate peripheral such as a debug interface takes over the pin. That peripheral supplies the pin's output enable and drive value, and the pull-up is forced off. After reset, these enable bits start set only on the pins given by a parameter: the pins that carry the debug interface. Every other pin starts as a floating input.

The pad inputs pass through a two-flop synchronizer into a read-only input register. The bus reads it like any other register.

Top module: `gpio_pad_port`

## Requirements
- R1: After reset, the output register and the direction register read 00h and the alternate-enable register reads DBG_PINS (default 0Fh). Every pin outside DBG_PINS then has pad_oe=0 and pad_pu=0.
- R2: The register offsets are: 0 = output data, 1 = direction, 2 = alternate enable, 3 = input (read-only). A write with bus_wr high updates the addressed register at that rising clock edge. bus_rdata is combinational from bus_addr. Unmapped offsets read 00h.
- R3: A pin with direction 0, output bit 0 and no alternate function is a floating input: pad_oe=0 and pad_pu=0.
- R4: A pin with direction 0, output bit 1 and no alternate function is an input with its weak pull-up on: pad_oe=0 and pad_pu=1.
- R5: A pin with direction 1 and no alternate function drives strongly: pad_oe=1, pad_out equals its output bit, and pad_pu=0.
- R6: A write to the direction register never changes the output register. A pin switched back to output drives the level written to it earlier.
- R7: A pin whose alternate-enable bit is 1 takes pad_oe from alt_oe and pad_out from alt_out, with pad_pu=0, whatever its direction and output bits are.
- R8: The input register returns pad_in as it was two rising edges earlier, whatever the pin directions are.
- R9: Writes to offset 3 or to any unmapped offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data of the addressed register |
| alt_oe | input | WIDTH | Alternate-function output enable per pin |
| alt_out | input | WIDTH | Alternate-function drive value per pin |
| pad_in | input | WIDTH | Pad input levels (asynchronous) |
| pad_oe | output | WIDTH | Pad output enable |
| pad_out | output | WIDTH | Pad drive value |
| pad_pu | output | WIDTH | Pad weak pull-up enable |

## Verification
The assertions take for granted that bus_wr, bus_addr and bus_wdata are stable around each rising edge. They also take for granted that pad_in changes only once per cycle, so the two-cycle synchronizer delay can be checked by comparing the input register with pad_in from two edges earlier. The stimulus meets both conditions. It changes every input only on the falling edge and reads results half a cycle after the edge they follow. pad_in is driven as a clean synchronous value, so no metastability window is modelled.

// File: rtl/gpio_pad_port.sv
module gpio_pad_port #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 4,
  parameter logic [WIDTH-1:0] DBG_PINS = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  alt_oe,
  input  logic [WIDTH-1:0]  alt_out,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu
);

  localparam logic [ADDR_W-1:0] OFS_OUT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DIR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_ALT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_IN  = ADDR_W'(3);

  logic [WIDTH-1:0] out_q, dir_q, alt_q, s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      alt_q <= DBG_PINS;
    end else if (bus_wr) begin
      if (bus_addr == OFS_OUT) out_q <= bus_wdata;
      if (bus_addr == OFS_DIR) dir_q <= bus_wdata;
      if (bus_addr == OFS_ALT) alt_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_OUT: bus_rdata = out_q;
      OFS_DIR: bus_rdata = dir_q;
      OFS_ALT: bus_rdata = alt_q;
      OFS_IN:  bus_rdata = s2_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_oe  = (alt_q & alt_oe)  | (~alt_q & dir_q);
  assign pad_out = (alt_q & alt_out) | (~alt_q & dir_q & out_q);
  assign pad_pu  = ~alt_q & ~dir_q & out_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_out_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_OUT) |=> (out_q == $past(bus_wdata)));

  p_pu_never_with_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  p_dir_keeps_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIR) |=> $stable(out_q));

  p_alt_no_pullup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & alt_q) == '0);

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (s2_q == $past(pad_in, 2)));

  p_input_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_IN) |=> ($stable(out_q) && $stable(dir_q) && $stable(alt_q)));

endmodule

// File: tb/tb_gpio_pad_port.sv
`timescale 1ns/100ps
module tb_gpio_pad_port;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, alt_oe = '0, alt_out = '0, pad_in = '0;
  logic [7:0] pad_oe, pad_out, pad_pu;
  int n_chk = 0, n_bad = 0;

  gpio_pad_port dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu));

  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); chk("R1", "out reset", v, 8'h00);
    rd(1, v); chk("R1", "dir reset", v, 8'h00);
    rd(2, v); chk("R1", "alt reset", v, 8'h0F);
    chk("R1", "oe non-debug pins", pad_oe & 8'hF0, 8'h00);
    chk("R1", "pu non-debug pins", pad_pu & 8'hF0, 8'h00);
    chk("R7", "debug pins follow alt_oe", pad_oe & 8'h0F, 8'h05);
    chk("R7", "debug pins follow alt_out", pad_out & 8'h0F, 8'h0A);
  endtask

  task automatic t_modes;
    logic [7:0] v;
    wr(2, 8'h00);
    rd(2, v); chk("R2", "alt readback", v, 8'h00);
    chk("R3", "all floating oe", pad_oe, 8'h00);
    chk("R3", "all floating pu", pad_pu, 8'h00);
    wr(0, 8'hAA);
    wr(1, 8'hF0);
    rd(0, v); chk("R2", "out readback", v, 8'hAA);
    rd(1, v); chk("R2", "dir readback", v, 8'hF0);
    chk("R4", "pull-ups on input pins", pad_pu, 8'h0A);
    chk("R5", "oe on output pins", pad_oe, 8'hF0);
    chk("R5", "drive on output pins", pad_out, 8'hA0);
  endtask

  task automatic t_dir_keep;
    logic [7:0] v;
    wr(1, 8'h00);
    rd(0, v); chk("R6", "out kept after dir write", v, 8'hAA);
    chk("R4", "all inputs pulled per out", pad_pu, 8'hAA);
    wr(1, 8'hFF);
    chk("R6", "drive restored", pad_out, 8'hAA);
    chk("R5", "all oe", pad_oe, 8'hFF);
    chk("R5", "no pu when driving", pad_pu, 8'h00);
  endtask

  task automatic t_alt;
    alt_oe = 8'h14; alt_out = 8'h28;
    wr(2, 8'h3C);
    chk("R7", "oe mix", pad_oe, 8'hD7);
    chk("R7", "out mix", pad_out, 8'hAA);
    wr(1, 8'h00);
    chk("R7", "oe mix inputs", pad_oe, 8'h14);
    chk("R7", "pu forced off on alt pins", pad_pu, 8'h82);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h5A;
    rd(3, v); chk("R8", "0 edges", v, 8'h00);
    @(negedge clk); rd(3, v); chk("R8", "1 edge", v, 8'h00);
    @(negedge clk); rd(3, v); chk("R8", "2 edges", v, 8'h5A);
    wr(1, 8'hFF);
    pad_in = 8'hC3;
    repeat (2) @(negedge clk);
    rd(3, v); chk("R8", "read with pins as outputs", v, 8'hC3);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    wr(3, 8'h77);
    wr(7, 8'h55);
    rd(0, v); chk("R9", "out unchanged", v, 8'hAA);
    rd(1, v); chk("R9", "dir unchanged", v, 8'hFF);
    rd(2, v); chk("R9", "alt unchanged", v, 8'h3C);
    rd(3, v); chk("R9", "input unchanged", v, 8'hC3);
    rd(7, v); chk("R2", "unmapped reads zero", v, 8'h00);
  endtask

  initial begin
    fork
      begin
        alt_oe = 8'h05; alt_out = 8'h0A;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_modes; t_dir_keep; t_alt; t_sync; t_ignored;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule